// File: doc/BRIEF.md
# USB Transmit Fill Scheduler

This block decides when a host-mode USB transmit packet is allowed to start on the bus. Packet data arrives in a latency FIFO as bursts. Before a packet is launched, the block checks two things. First, enough bursts must already be posted to that FIFO. Second, the packet plus a programmable safety margin must still fit in the time that remains before the next Start-Of-Frame. If the packet fits, the block pulses `go`. If it does not fit, the block pulses `backoff` and waits for the next frame. A backoff that happens while the FIFO was still short of its fill level is counted in a small health counter, which software uses to tune the margin.

All timing inputs are given in units of 1.267 µs, the margin unit at high speed. At low or full speed one margin unit lasts 6.333 µs, which is five of these units. The block therefore scales the margin by five when high speed is not selected. In streaming mode, the FIFO fill level is compared with a burst threshold. With streaming turned off, the threshold is ignored and the whole packet must be in the FIFO.

A single 32-bit register holds three fields:
- the margin (overhead) in bits 7:0;
- the health counter in bits 12:8;
- the fill threshold in bits 21:16.

All other bits read as zero. A write loads the margin and the threshold, and clears the health counter.

Top module: `usb_txfill_sched`

## Requirements
- R1: After reset, `reg_rdata` reads 32'h0002_0000: threshold 2, overhead 0, health 0. With `req` low, neither `go` nor `backoff` is asserted.
- R2: A write with `reg_wr` high does three things. It loads the overhead from `reg_wdata[7:0]`. It loads the threshold from `reg_wdata[21:16]`. It clears the health counter in bits 12:8. All of these take effect at the next clock edge, and the fields read back at the same positions.
- R3: A threshold value below 2 is stored and read back as 2.
- R4: With `stream_dis` low, an evaluated request pulses `go` when the deadline test passes and either `fifo_bursts >= threshold` or `fifo_bursts >= pkt_bursts`.
- R5: When the deadline test passes but the fill condition is not met, neither output pulses and the request stays pending.
- R6: With `stream_dis` high, the threshold is ignored and `go` requires `fifo_bursts >= pkt_bursts`.
- R7: The deadline test passes when `pkt_time + overhead_units <= time_left`. Otherwise an evaluated request pulses `backoff`, whatever the fill level.
- R8: `overhead_units` equals the overhead when `hs_mode` is high, and five times the overhead when `hs_mode` is low.
- R9: After a `backoff`, a pending request is not evaluated again until a cycle with `sof` high has passed. It is then re-evaluated in the following cycle.
- R10: After a `go`, no further pulse occurs until `req` has gone low. Each request therefore receives exactly one `go`.
- R11: The health counter increments by one on each `backoff` issued while the fill condition is not met. A `backoff` issued with the fill condition met leaves it unchanged.
- R12: The health counter saturates at 31 instead of wrapping.
- R13: `go` and `backoff` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| fifo_bursts | input | 6 | Bursts posted to the latency FIFO for the current packet |
| pkt_bursts | input | 6 | Bursts that make up the whole packet |
| time_left | input | TIME_W | Time remaining before the next Start-Of-Frame, in 1.267 µs units |
| pkt_time | input | TIME_W | Estimated packet duration, in 1.267 µs units |
| hs_mode | input | 1 | High-speed device attached |
| stream_dis | input | 1 | Streaming disabled: the whole packet must be buffered |
| sof | input | 1 | Start-Of-Frame pulse |
| req | input | 1 | Packet request pending |
| go | output | 1 | Packet may start (one-cycle pulse) |
| backoff | output | 1 | Packet backed off until the next frame (one-cycle pulse) |

## Verification
Requests are presented in several situations:
- The FIFO is below the threshold, then reaches it. This separates the waiting case from a launch.
- The packet is smaller than the threshold. This shows that a fully buffered packet is never stalled.
- Streaming is disabled with the fill above the threshold but short of the full packet. This shows that the threshold is really ignored.

The deadline is probed on both sides of the boundary, at equality and one unit short, at both speed settings. This separates the scaling by one from the scaling by five.

Backoffs are issued both with and without the fill condition met, which separates counted from uncounted events. Repeated backoffs, one per frame, drive the health counter into saturation.

// File: rtl/usb_txfill_sched.sv
module usb_txfill_sched #(
  parameter int TIME_W   = 16,
  parameter int LS_SCALE = 5,
  localparam int THR_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [THR_W-1:0]  fifo_bursts,
  input  logic [THR_W-1:0]  pkt_bursts,
  input  logic [TIME_W-1:0] time_left,
  input  logic [TIME_W-1:0] pkt_time,
  input  logic              hs_mode,
  input  logic              stream_dis,
  input  logic              sof,
  input  logic              req,
  output logic              go,
  output logic              backoff
);
  localparam int OVH_W  = 8;
  localparam int HLT_W  = 5;
  localparam int NEED_W = ((TIME_W > OVH_W + 4) ? TIME_W : OVH_W + 4) + 1;
  localparam logic [THR_W-1:0] THR_MIN = THR_W'(2);
  localparam logic [HLT_W-1:0] HLT_MAX = '1;

  logic [OVH_W-1:0] ovh_q;
  logic [HLT_W-1:0] hlt_q;
  logic [THR_W-1:0] thr_q;
  logic             hold_q, done_q;

  logic [THR_W-1:0] thr_wr;
  logic [NEED_W-1:0] ovh_units, need;
  logic fill_ok, time_ok, eval;
  logic unused_wbits;

  assign thr_wr = reg_wdata[21:16];
  assign unused_wbits = ^{reg_wdata[31:22], reg_wdata[15:8]};

  assign fill_ok = stream_dis ? (fifo_bursts >= pkt_bursts)
                              : (fifo_bursts >= thr_q) || (fifo_bursts >= pkt_bursts);

  assign ovh_units = hs_mode ? NEED_W'(ovh_q) : NEED_W'(ovh_q) * NEED_W'(LS_SCALE);
  assign need      = NEED_W'(pkt_time) + ovh_units;
  assign time_ok   = need <= NEED_W'(time_left);

  assign eval    = req && !hold_q && !done_q;
  assign go      = eval && time_ok && fill_ok;
  assign backoff = eval && !time_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovh_q <= '0;
      thr_q <= THR_MIN;
      hlt_q <= '0;
    end else if (reg_wr) begin
      ovh_q <= reg_wdata[OVH_W-1:0];
      thr_q <= (thr_wr < THR_MIN) ? THR_MIN : thr_wr;
      hlt_q <= '0;
    end else if (backoff && !fill_ok && hlt_q != HLT_MAX) begin
      hlt_q <= hlt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (backoff)  hold_q <= 1'b1;
      else if (sof) hold_q <= 1'b0;
      if (go)       done_q <= 1'b1;
      else if (!req) done_q <= 1'b0;
    end
  end

  assign reg_rdata = {10'd0, thr_q, 3'd0, hlt_q, ovh_q};
endmodule

// File: rtl/usb_txfill_sched_chk.sv
module usb_txfill_sched_chk #(
  parameter int TIME_W = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [4:0] hlt,
  input logic [5:0] thr,
  input logic [5:0] fifo_bursts,
  input logic [5:0] pkt_bursts,
  input logic       stream_dis,
  input logic       go,
  input logic       backoff
);
  AST_GO_BO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && backoff)); // R13
  AST_THR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    thr >= 6'd2); // R3
  AST_GO_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (fifo_bursts >= pkt_bursts) || (!stream_dis && fifo_bursts >= 6'd2)); // R6
  AST_BO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    backoff |=> !go && !backoff); // R9
  AST_ONE_GO: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go); // R10
  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> hlt == 5'd0); // R2
  AST_HLT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (hlt == 5'd31 && !reg_wr) |=> hlt == 5'd31); // R12
endmodule

bind usb_txfill_sched usb_txfill_sched_chk #(.TIME_W(TIME_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
  .hlt(reg_rdata[12:8]), .thr(reg_rdata[21:16]),
  .fifo_bursts(fifo_bursts), .pkt_bursts(pkt_bursts),
  .stream_dis(stream_dis), .go(go), .backoff(backoff)
);

// File: tb/usb_txfill_sched_tb_top.sv
module usb_txfill_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TIME_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [5:0] fifo_bursts = '0, pkt_bursts = '0;
  logic [TIME_W-1:0] time_left = '0, pkt_time = '0;
  logic hs_mode = 1'b1, stream_dis = 1'b0, sof = 1'b0, req = 1'b0;
  logic go, backoff;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_txfill_sched #(.TIME_W(TIME_W)) dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic look(string tag, logic eg, logic eb);
    #1;
    chk({tag, " go"}, 32'(go), 32'(eg));
    chk({tag, " backoff"}, 32'(backoff), 32'(eb));
    chk("R13 exclusive", 32'(go && backoff), 32'd0);
  endtask

  task automatic wr(logic [7:0] ovh, logic [5:0] thr);
    tick();
    reg_wr = 1'b1;
    reg_wdata = {10'd0, thr, 3'd7, 5'h1f, ovh};
    tick();
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic idle();
    tick();
    req = 1'b0; sof = 1'b1;
    tick();
    sof = 1'b0;
  endtask

  task automatic t_reset();
    tick();
    chk("R1 reset rdata", reg_rdata, 32'h0002_0000);
    look("R1 idle", 1'b0, 1'b0);
  endtask

  task automatic t_regs();
    wr(8'd3, 6'd5);
    #1 chk("R2 readback", reg_rdata, 32'h0005_0003);
    wr(8'd3, 6'd1);
    #1 chk("R3 clamp 1", reg_rdata[21:16], 32'd2);
    wr(8'd3, 6'd0);
    #1 chk("R3 clamp 0", reg_rdata[21:16], 32'd2);
  endtask

  task automatic t_stream_fill();
    wr(8'd2, 6'd4);
    tick();
    hs_mode = 1; stream_dis = 0; time_left = 100; pkt_time = 10;
    pkt_bursts = 8; fifo_bursts = 3; req = 1;
    look("R5 below threshold", 1'b0, 1'b0);
    tick(); fifo_bursts = 4;
    look("R4 threshold reached", 1'b1, 1'b0);
    tick();
    look("R10 single go", 1'b0, 1'b0);
    idle();
    pkt_bursts = 2; fifo_bursts = 2; req = 1;
    look("R4 whole small packet", 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_nostream();
    stream_dis = 1; pkt_bursts = 8; fifo_bursts = 5; req = 1;
    look("R6 threshold ignored", 1'b0, 1'b0);
    tick(); fifo_bursts = 8;
    look("R6 full packet", 1'b1, 1'b0);
    idle();
    stream_dis = 0;
  endtask

  task automatic t_deadline();
    fifo_bursts = 8; pkt_bursts = 8; hs_mode = 1; pkt_time = 10; time_left = 12;
    req = 1;
    look("R7 exact fit", 1'b1, 1'b0);
    tick(); req = 0;
    tick(); time_left = 11; req = 1;
    look("R7 one short", 1'b0, 1'b1);
    tick();
    look("R9 held", 1'b0, 1'b0);
    chk("R11 filled backoff uncounted", reg_rdata[12:8], 32'd0);
    sof = 1;
    look("R9 held in sof", 1'b0, 1'b0);
    tick(); sof = 0; time_left = 100;
    look("R9 re-evaluated", 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_speed();
    hs_mode = 0; pkt_time = 10; time_left = 19; req = 1;
    look("R8 low speed short", 1'b0, 1'b1);
    tick(); sof = 1;
    tick(); sof = 0; time_left = 20;
    look("R8 low speed fit", 1'b1, 1'b0);
    idle();
    hs_mode = 1;
  endtask

  task automatic t_health();
    wr(8'd2, 6'd4);
    tick();
    pkt_bursts = 8; fifo_bursts = 1; pkt_time = 10; time_left = 5; req = 1;
    look("R11 short backoff", 1'b0, 1'b1);
    tick(); #1;
    chk("R11 counted", reg_rdata[12:8], 32'd1);
    for (int i = 0; i < 40; i++) begin
      sof = 1;
      tick(); sof = 0;
      tick();
    end
    #1 chk("R12 saturated", reg_rdata[12:8], 32'd31);
    idle();
    wr(8'd2, 6'd4);
    #1 chk("R2 write clears", reg_rdata[12:8], 32'd0);
    chk("R2 fields kept", reg_rdata, 32'h0004_0002);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    tick();
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_stream_fill();
    t_nostream();
    t_deadline();
    t_speed();
    t_health();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule